// File: doc/BRIEF.md
# Double-Step Xoroshiro32++ Generator Unit

This unit produces 32 bits of pseudo-random data per operation from a 32-bit generator state held as two 16-bit halves. A single operation runs two xoroshiro iterations back to back inside one clock. Each iteration scrambles the state with fixed shift and rotate amounts. Each iteration also produces a 16-bit word through a "plus-plus" output function: two additions in series, with a rotate between them. The two words are joined into one 32-bit result.

The caller owns the state. It presents the current state on `seed_in` and pulses `go`. On the next clock the unit returns the advanced state on `state_out`, the random word on `rand_out`, and a one-cycle `rand_vld` flag. Feeding `state_out` back into `seed_in` walks the sequence. No parity bit is produced.

Top module: `xs_dual_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first operation, `state_out` and `rand_out` read zero and `rand_vld` reads 0.
- R2: In both `seed_in` and `state_out`, half s0 occupies bits [15:0] and half s1 occupies bits [31:16].
- R3: One step computes t = s1 ^ s0, then new s0 = rotl16(s0, 14) ^ t ^ (t << 2) and new s1 = rotl16(t, 7).
- R4: The word of one step is rotl16(s0 + s1, 5) + s0, taken from the state before that step. Both additions wrap modulo 2^16.
- R5: One operation applies two steps in series. `state_out` is the state after the second step.
- R6: `rand_out[15:0]` holds the first step's word and `rand_out[31:16]` holds the second step's word. No parity bit is added.
- R7: When `go` is high at a rising clock edge, the results of that operation appear after that edge and `rand_vld` is 1 for that one cycle. After an edge with `go` low, `rand_vld` is 0.
- R8: After an edge with `go` low, `state_out` and `rand_out` keep their values whatever `seed_in` does.
- R9: An all-zero seed gives an all-zero `state_out` and an all-zero `rand_out`, with `rand_vld` still raised.
- R10: Operations on consecutive cycles, with `state_out` fed back to `seed_in`, follow the recurrence for at least 1000 operations from a nonzero seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start one double-step operation |
| seed_in | input | 32 | Current generator state {s1, s0} |
| state_out | output | 32 | State after two steps {s1, s0} |
| rand_out | output | 32 | {second word, first word} |
| rand_vld | output | 1 | High for the cycle after an operation starts |

## Verification
The assertions assume that `go` and `seed_in` are known values at every rising edge after reset, and that `go` alone decides whether the registers load. The stimulus drives both inputs only on falling edges, so each input is settled well before the edge that samples it. The stimulus also keeps `go` at 0 during reset. Any seed value is legal, including zero, so the stimulus puts no limit on `seed_in`. It deliberately changes `seed_in` while `go` is low to exercise the hold behaviour.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int unsigned XS_HW = 16;
  typedef logic [XS_HW-1:0] half_t;

  // left rotate of one half word by k places
  function automatic half_t rotl(input half_t x, input int unsigned k);
    return half_t'((x << k) | (x >> (XS_HW - k)));
  endfunction

  // modular add of two half words
  function automatic half_t add_w(input half_t x, input half_t y);
    return half_t'(x + y);
  endfunction

  // plus-plus output word of one step, from the pre-step halves
  function automatic half_t pp_word(input half_t s0, input half_t s1, input int unsigned d);
    return add_w(rotl(add_w(s0, s1), d), s0);
  endfunction
endpackage

// File: rtl/xs_step.sv
module xs_step
  import xs_pkg::*;
#(
  parameter int unsigned SH_A = 14,
  parameter int unsigned SH_B = 2,
  parameter int unsigned SH_C = 7,
  parameter int unsigned SH_D = 5
) (
  input  half_t s0_i,
  input  half_t s1_i,
  output half_t s0_o,
  output half_t s1_o,
  output half_t word_o
);
  half_t mix;
  half_t sum_first;

  always_comb begin
    mix       = s1_i ^ s0_i;
    s0_o      = rotl(s0_i, SH_A) ^ mix ^ half_t'(mix << SH_B);
    s1_o      = rotl(mix, SH_C);
    sum_first = add_w(s0_i, s1_i);
    word_o    = pp_word(s0_i, s1_i, SH_D);
  end
endmodule

// File: rtl/xs_chain.sv
module xs_chain
  import xs_pkg::*;
#(
  parameter int unsigned N_STEP = 2,
  parameter int unsigned SH_A   = 14,
  parameter int unsigned SH_B   = 2,
  parameter int unsigned SH_C   = 7,
  parameter int unsigned SH_D   = 5,
  localparam int unsigned ST_W  = 2 * XS_HW,
  localparam int unsigned RN_W  = N_STEP * XS_HW
) (
  input  logic [ST_W-1:0] st_i,
  output logic [ST_W-1:0] st_o,
  output logic [RN_W-1:0] rn_o
);
  half_t lo_s [N_STEP+1];
  half_t hi_s [N_STEP+1];

  assign lo_s[0] = st_i[XS_HW-1:0];
  assign hi_s[0] = st_i[ST_W-1:XS_HW];

  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    half_t w;
    xs_step #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C), .SH_D(SH_D)) u_step (
      .s0_i   (lo_s[g]),
      .s1_i   (hi_s[g]),
      .s0_o   (lo_s[g+1]),
      .s1_o   (hi_s[g+1]),
      .word_o (w)
    );
    assign rn_o[g*XS_HW +: XS_HW] = w;
  end

  assign st_o = {hi_s[N_STEP], lo_s[N_STEP]};
endmodule

// File: rtl/xs_dual_top.sv
module xs_dual_top
  import xs_pkg::*;
#(
  parameter int unsigned N_STEP = 2,
  parameter int unsigned SH_A   = 14,
  parameter int unsigned SH_B   = 2,
  parameter int unsigned SH_C   = 7,
  parameter int unsigned SH_D   = 5,
  localparam int unsigned ST_W  = 2 * XS_HW,
  localparam int unsigned RN_W  = N_STEP * XS_HW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [ST_W-1:0] seed_in,
  output logic [ST_W-1:0] state_out,
  output logic [RN_W-1:0] rand_out,
  output logic            rand_vld
);
  logic [ST_W-1:0] nxt_state;
  logic [RN_W-1:0] nxt_rand;
  logic            load_ev;

  assign load_ev = go;

  xs_chain #(
    .N_STEP(N_STEP), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C), .SH_D(SH_D)
  ) u_chain (
    .st_i (seed_in),
    .st_o (nxt_state),
    .rn_o (nxt_rand)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_out <= '0;
      rand_out  <= '0;
      rand_vld  <= 1'b0;
    end else begin
      rand_vld <= load_ev;
      if (load_ev) begin
        state_out <= nxt_state;
        rand_out  <= nxt_rand;
      end
    end
  end
endmodule

// File: rtl/xs_dual_chk.sv
module xs_dual_chk #(
  parameter int unsigned ST_W = 32,
  parameter int unsigned RN_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic [ST_W-1:0] seed_in,
  input logic [ST_W-1:0] state_out,
  input logic [RN_W-1:0] rand_out,
  input logic            rand_vld
);
  // R7
  vld_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> rand_vld);

  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !rand_vld);

  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(state_out) && $stable(rand_out));

  // R9
  zero_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && seed_in == '0) |=> (state_out == '0 && rand_out == '0));

  // R1
  always_comb begin
    if (!rst_n) begin
      rst_clear_chk: assert (state_out == '0 && rand_out == '0 && !rand_vld);
    end
  end
endmodule

bind xs_dual_top xs_dual_chk #(.ST_W(ST_W), .RN_W(RN_W)) u_dual_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .seed_in   (seed_in),
  .state_out (state_out),
  .rand_out  (rand_out),
  .rand_vld  (rand_vld)
);

// File: tb/test_xs_dual_top.sv
module test_xs_dual_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [31:0] seed_in;
  logic [31:0] state_out;
  logic [31:0] rand_out;
  logic        rand_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xs_dual_top i_xs_dual_top (
    .clk(clk), .rst_n(rst_n), .go(go), .seed_in(seed_in),
    .state_out(state_out), .rand_out(rand_out), .rand_vld(rand_vld)
  );

  localparam int NV = 8;
  localparam logic [31:0] SEEDS [NV] = '{
    32'h0000_0001, 32'h0001_0000, 32'hFFFF_FFFF, 32'h8000_8000,
    32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'hA5A5_005A
  };

  // rotate by taking the upper half of a doubled word shifted left
  function automatic logic [15:0] rl(input logic [15:0] v, input int k);
    logic [31:0] dd;
    dd = {v, v} << k;
    return dd[31:16];
  endfunction

  // two model steps; R2 R3 R4 R5 R6
  task automatic model(input logic [31:0] st, output logic [31:0] nst,
                       output logic [31:0] rn);
    logic [15:0] a, b, t, w;
    logic [15:0] ws [2];
    a = st[15:0];
    b = st[31:16];
    for (int i = 0; i < 2; i++) begin
      w = a + b;
      w = rl(w, 5);
      ws[i] = w + a;
      t = a ^ b;
      a = rl(a, 14) ^ t ^ {t[13:0], 2'b00};
      b = rl(t, 7);
    end
    nst = {b, a};
    rn  = {ws[1], ws[0]};
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_up();
    end
  end

  initial begin
    logic [31:0] es, er, st, hs, hr;
    rst_n = 1'b0; go = 1'b0; seed_in = 32'h5555_AAAA;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 state", state_out, 0);
    chk("R1 rand", rand_out, 0);
    chk("R1 vld", {31'd0, rand_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {rand_out[30:0], rand_vld} | state_out, 0);

    // table of seeds: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      model(SEEDS[i], es, er);
      seed_in = SEEDS[i];
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk("R3 R5 state", state_out, es);
      chk("R4 R6 rand", rand_out, er);
      chk("R7 vld high", {31'd0, rand_vld}, 1);
      @(negedge clk);
      chk("R7 vld low", {31'd0, rand_vld}, 0);
    end

    // R8: hold with go low while seed changes
    hs = state_out; hr = rand_out;
    for (int i = 0; i < 4; i++) begin
      seed_in = 32'h1357_9BDF + 32'(i) * 32'h0101_0101;
      @(negedge clk);
      chk("R8 state hold", state_out, hs);
      chk("R8 rand hold", rand_out, hr);
    end

    // R9: zero seed
    seed_in = 32'h0; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R9 state", state_out, 0);
    chk("R9 rand", rand_out, 0);
    chk("R9 vld", {31'd0, rand_vld}, 1);

    // R10: 1000 consecutive fed-back operations
    st = 32'h0000_0001;
    seed_in = st; go = 1'b1;
    for (int n = 0; n < 1000; n++) begin
      model(st, es, er);
      @(negedge clk);
      chk("R10 state", state_out, es);
      chk("R10 rand", rand_out, er);
      st = state_out;
      seed_in = state_out;
    end
    go = 1'b0;
    @(negedge clk);
    chk("R7 vld drop", {31'd0, rand_vld}, 0);

    done = 1'b1;
    finish_up();
  end
endmodule